// File: doc/BRIEF.md
# Exception Control Register File

This block keeps the exception state of a small 32-bit processor core. It holds four registers that the core reaches by a 5-bit register number. A move-to port writes them and a move-from port reads them. The four are a fault-address register, a status register, a cause register and an exception return address register. When the core signals an exception, the block does three things in a single clock edge. It saves the address of the offending instruction. It saves the bad memory address when the exception is an address error. It records the exception code, and it pushes a small stack of privilege and interrupt-enable pairs so that the core ends up in kernel mode with interrupts off.

The block also samples eight external interrupt lines into sticky pending bits. It gates them with a per-level mask and the current interrupt enable, and drives a registered interrupt request back to the core. When the core takes that request it reports an exception with code 0. A return-from-exception strobe pops the privilege/enable stack.

Top module: `exc_ctrl_regs`

## Requirements
- R1: Move-from data is registered. A read of number N in one cycle appears on `mf_data` after the next rising edge and shows the state before that edge's updates. Number 8 is the fault address and number 14 is the return address. Number 12 is status, with the mask in bits 15:8 and the stack in bits 5:0. The stack bits are bit0 IE-current, bit1 KU-current, bit2 IE-previous, bit3 KU-previous, bit4 IE-old and bit5 KU-old. Number 13 is cause, with the code in bits 6:2 and pending in bits 15:8. All other bits, and all other numbers, read as 0.
- R2: A move-to write of status loads the mask and the stack bits. A write of number 14 loads the return address. A write of cause loads only the pending bits, and its code field cannot be written. Writes to number 8 or to any unmapped number change nothing.
- R3: On `exc_req`, the return address register takes `exc_pc` and the cause code field takes `exc_code`.
- R4: The fault-address register takes `exc_addr` only on an exception with code 4 (address error on load or fetch) or code 5 (address error on store). Other codes leave it unchanged.
- R5: On `exc_req`, the stack bits shift left by two and the current pair becomes 00, which is kernel mode with interrupts disabled. The mask is unchanged.
- R6: On `rfe`, the stack bits shift right by two: current takes previous and previous takes old. The old pair and the mask are unchanged.
- R7: A pending bit is set in any cycle in which its line is high, and it stays set after the line falls. A move-to write of cause replaces the pending bits with the written bits ORed with the lines that are high in that cycle.
- R8: `irq_req` is a register. It is 1 one edge after (pending AND mask) is nonzero while IE-current is 1, and 0 otherwise.
- R9: An exception in the same cycle as a move-to write of the same register drops the write. `rfe` in the same cycle as a move-to write of status drops the write. An exception in the same cycle as `rfe` performs the push.
- R10: A synchronous reset clears every register, `mf_data` and `irq_req`. This leaves kernel mode with interrupts disabled and nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_en | input | 1 | Move-to write strobe |
| mt_num | input | 5 | Move-to register number |
| mt_data | input | 32 | Move-to write data |
| mf_num | input | 5 | Move-from register number |
| mf_data | output | 32 | Registered move-from read data |
| exc_req | input | 1 | Exception taken this cycle |
| exc_code | input | 5 | Exception code for `exc_req` |
| exc_pc | input | 32 | Address of the offending instruction |
| exc_addr | input | 32 | Offending data address, used for codes 4 and 5 |
| rfe | input | 1 | Return-from-exception strobe |
| irq_lines | input | 8 | External interrupt lines, one per level |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
An exception can land in the same cycle as a move-to write of the cause or return-address register, and `rfe` can land in the same cycle as a status write. The bench drives such collisions on purpose. It then reads the register back and confirms that the exception's values, or the popped stack, survive and that the written data does not appear. It also raises an interrupt line during a cause write, to show that a line held high keeps its pending bit set against a write of zero.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  // Register numbers seen by move-to / move-from
  localparam int REG_FAULT_ADDR = 8;
  localparam int REG_STATUS     = 12;
  localparam int REG_CAUSE      = 13;
  localparam int REG_RET_PC     = 14;

  // Field positions inside status and cause words
  localparam int MASK_LSB  = 8;
  localparam int CODE_LSB  = 2;
  localparam int STACK_W   = 6;

  typedef enum logic [4:0] {
    EXC_INTERRUPT  = 5'd0,
    EXC_ADDR_LOAD  = 5'd4,
    EXC_ADDR_STORE = 5'd5,
    EXC_BUS_FETCH  = 5'd6,
    EXC_BUS_DATA   = 5'd7,
    EXC_SYSCALL    = 5'd8,
    EXC_BREAK      = 5'd9,
    EXC_BAD_INSTR  = 5'd10,
    EXC_OVERFLOW   = 5'd12
  } exc_code_e;
endpackage

// File: rtl/exc_status_reg.sv
`timescale 1ns/1ps
module exc_status_reg #(
  parameter int IRQ_N   = 8,
  parameter int STACK_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_take,
  input  logic               rfe,
  input  logic               wr_en,
  input  logic [IRQ_N-1:0]   wr_mask,
  input  logic [STACK_W-1:0] wr_stack,
  output logic [IRQ_N-1:0]   mask,
  output logic [STACK_W-1:0] stack
);
  // Exception push beats return pop beats software write.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '0;
      stack <= '0;
    end else if (exc_take) begin
      stack <= {stack[STACK_W-3:0], 2'b00};
    end else if (rfe) begin
      stack <= {stack[STACK_W-1:STACK_W-2], stack[STACK_W-1:2]};
    end else if (wr_en) begin
      mask  <= wr_mask;
      stack <= wr_stack;
    end
  end

  p_push_r5: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> stack == {$past(stack[STACK_W-3:0]), 2'b00});
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (exc_take || rfe) |=> $stable(mask));
  p_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (rfe && !exc_take) |=> stack == {$past(stack[STACK_W-1:STACK_W-2]), $past(stack[STACK_W-1:2])});
endmodule

// File: rtl/exc_cause_reg.sv
`timescale 1ns/1ps
module exc_cause_reg #(
  parameter int IRQ_N  = 8,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              wr_en,
  input  logic [IRQ_N-1:0]  wr_pend,
  input  logic [IRQ_N-1:0]  irq_lines,
  output logic [IRQ_N-1:0]  pend,
  output logic [CODE_W-1:0] code
);
  // A write only lands when no exception touches cause in the same cycle.
  logic wr_live;
  assign wr_live = wr_en && !exc_take;

  always_ff @(posedge clk) begin
    if (rst)           code <= '0;
    else if (exc_take) code <= exc_code;
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)          pend[i] <= 1'b0;
      else if (wr_live) pend[i] <= wr_pend[i] | irq_lines[i];
      else              pend[i] <= pend[i] | irq_lines[i];
    end
  end

  p_code_capture_r3: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> code == $past(exc_code));
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_live |=> (pend & $past(pend)) == $past(pend));
  p_line_sets_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend & $past(irq_lines)) == $past(irq_lines));
endmodule

// File: rtl/exc_irq_gen.sv
`timescale 1ns/1ps
module exc_irq_gen #(
  parameter int IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] pend,
  input  logic [IRQ_N-1:0] mask,
  input  logic             ie,
  output logic             irq_req
);
  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= ie && (|(pend & mask));
  end

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq_req);
endmodule

// File: rtl/exc_ctrl_regs.sv
`timescale 1ns/1ps
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 5,
  parameter int IRQ_N  = 8,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mt_en,
  input  logic [NUM_W-1:0]  mt_num,
  input  logic [DATA_W-1:0] mt_data,
  input  logic [NUM_W-1:0]  mf_num,
  output logic [DATA_W-1:0] mf_data,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [DATA_W-1:0] exc_pc,
  input  logic [DATA_W-1:0] exc_addr,
  input  logic              rfe,
  input  logic [IRQ_N-1:0]  irq_lines,
  output logic              irq_req
);
  localparam logic [NUM_W-1:0] N_FAULT  = NUM_W'(REG_FAULT_ADDR);
  localparam logic [NUM_W-1:0] N_STATUS = NUM_W'(REG_STATUS);
  localparam logic [NUM_W-1:0] N_CAUSE  = NUM_W'(REG_CAUSE);
  localparam logic [NUM_W-1:0] N_RETPC  = NUM_W'(REG_RET_PC);
  localparam logic [CODE_W-1:0] C_ADDR_LD = CODE_W'(EXC_ADDR_LOAD);
  localparam logic [CODE_W-1:0] C_ADDR_ST = CODE_W'(EXC_ADDR_STORE);

  // Write decode
  logic wr_status, wr_cause, wr_retpc;
  assign wr_status = mt_en && (mt_num == N_STATUS);
  assign wr_cause  = mt_en && (mt_num == N_CAUSE);
  assign wr_retpc  = mt_en && (mt_num == N_RETPC);

  logic addr_fault;
  assign addr_fault = (exc_code == C_ADDR_LD) || (exc_code == C_ADDR_ST);

  // Status
  logic [IRQ_N-1:0]   mask;
  logic [STACK_W-1:0] stack;
  exc_status_reg #(.IRQ_N(IRQ_N), .STACK_W(STACK_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .exc_take (exc_req),
    .rfe      (rfe),
    .wr_en    (wr_status),
    .wr_mask  (mt_data[MASK_LSB +: IRQ_N]),
    .wr_stack (mt_data[STACK_W-1:0]),
    .mask     (mask),
    .stack    (stack)
  );

  // Cause
  logic [IRQ_N-1:0]  pend;
  logic [CODE_W-1:0] code;
  exc_cause_reg #(.IRQ_N(IRQ_N), .CODE_W(CODE_W)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .exc_take  (exc_req),
    .exc_code  (exc_code),
    .wr_en     (wr_cause),
    .wr_pend   (mt_data[MASK_LSB +: IRQ_N]),
    .irq_lines (irq_lines),
    .pend      (pend),
    .code      (code)
  );

  // Interrupt request
  exc_irq_gen #(.IRQ_N(IRQ_N)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .mask    (mask),
    .ie      (stack[0]),
    .irq_req (irq_req)
  );

  // Return address and fault address
  logic [DATA_W-1:0] retpc_q, fault_q;
  always_ff @(posedge clk) begin
    if (rst)           retpc_q <= '0;
    else if (exc_req)  retpc_q <= exc_pc;
    else if (wr_retpc) retpc_q <= mt_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                          fault_q <= '0;
    else if (exc_req && addr_fault)   fault_q <= exc_addr;
  end

  // Read words
  logic [DATA_W-1:0] status_word, cause_word;
  always_comb begin
    status_word = '0;
    status_word[MASK_LSB +: IRQ_N] = mask;
    status_word[STACK_W-1:0]       = stack;
    cause_word  = '0;
    cause_word[MASK_LSB +: IRQ_N]  = pend;
    cause_word[CODE_LSB +: CODE_W] = code;
  end

  always_ff @(posedge clk) begin
    if (rst) mf_data <= '0;
    else begin
      case (mf_num)
        N_FAULT:  mf_data <= fault_q;
        N_STATUS: mf_data <= status_word;
        N_CAUSE:  mf_data <= cause_word;
        N_RETPC:  mf_data <= retpc_q;
        default:  mf_data <= '0;
      endcase
    end
  end

  p_retpc_capture_r3: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> retpc_q == $past(exc_pc));
  p_fault_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(exc_req && addr_fault) |=> $stable(fault_q));
  p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (stack[0] && (|(pend & mask))) |=> irq_req);
  p_retpc_prio_r9: assert property (@(posedge clk) disable iff (rst)
    (exc_req && wr_retpc) |=> retpc_q == $past(exc_pc));
endmodule

// File: tb/test_exc_ctrl_regs.sv
`timescale 1ns/1ps
module test_exc_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mt_en = 1'b0;
  logic [4:0]  mt_num = '0;
  logic [31:0] mt_data = '0;
  logic [4:0]  mf_num = '0;
  logic [31:0] mf_data;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic [31:0] exc_addr = '0;
  logic        rfe = 1'b0;
  logic [7:0]  irq_lines = '0;
  logic        irq_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  exc_ctrl_regs i_exc_ctrl_regs (
    .clk(clk), .rst(rst), .mt_en(mt_en), .mt_num(mt_num), .mt_data(mt_data),
    .mf_num(mf_num), .mf_data(mf_data), .exc_req(exc_req), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_addr(exc_addr), .rfe(rfe), .irq_lines(irq_lines),
    .irq_req(irq_req)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  wnum;
    logic [31:0] wdat;
    logic [4:0]  rnum;
    logic        exc;
    logic [4:0]  code;
    logic [31:0] pc;
    logic [31:0] addr;
    logic        ret;
    logic [7:0]  lines;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  // Each row is applied for one cycle; exp_rd is the register value before that cycle.
  localparam vec_t TBL [0:17] = '{
    '{1'b1, 5'd12, 32'h0000FF05, 5'd12, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00000000, 4'd10}, // R10 reset status
    '{1'b0, 5'd0,  32'h0,        5'd12, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h0000FF05, 4'd2},  // R2 status write
    '{1'b0, 5'd0,  32'h0,        5'd12, 1'b1, 5'd4,  32'h400,   32'h1233,   1'b0, 8'h0, 32'h0000FF05, 4'd1},  // R1 pre-update read
    '{1'b0, 5'd0,  32'h0,        5'd12, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h0000FF14, 4'd5},  // R5 push
    '{1'b0, 5'd0,  32'h0,        5'd14, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00000400, 4'd3},  // R3 pc
    '{1'b0, 5'd0,  32'h0,        5'd8,  1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00001233, 4'd4},  // R4 capture
    '{1'b0, 5'd0,  32'h0,        5'd13, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00000010, 4'd3},  // R3 code
    '{1'b0, 5'd0,  32'h0,        5'd13, 1'b0, 5'd0,  32'h0,     32'h0,      1'b1, 8'h0, 32'h00000010, 4'd1},  // R1 cause
    '{1'b0, 5'd0,  32'h0,        5'd12, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h0000FF15, 4'd6},  // R6 pop
    '{1'b1, 5'd14, 32'h00000999, 5'd8,  1'b1, 5'd8,  32'h500,   32'hDEAD,   1'b0, 8'h0, 32'h00001233, 4'd4},  // R4 before
    '{1'b0, 5'd0,  32'h0,        5'd8,  1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00001233, 4'd4},  // R4 hold
    '{1'b0, 5'd0,  32'h0,        5'd14, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00000500, 4'd9},  // R9 exc over write
    '{1'b0, 5'd0,  32'h0,        5'd13, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00000020, 4'd3},  // R3 syscall code
    '{1'b1, 5'd8,  32'h0000FFFF, 5'd12, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h0000FF14, 4'd5},  // R5 push again
    '{1'b0, 5'd0,  32'h0,        5'd8,  1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00001233, 4'd2},  // R2 fault write ignored
    '{1'b1, 5'd20, 32'h00000ABC, 5'd20, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00000000, 4'd1},  // R1 unmapped
    '{1'b1, 5'd14, 32'h12345678, 5'd14, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h00000500, 4'd2},  // R2 pc before
    '{1'b0, 5'd0,  32'h0,        5'd14, 1'b0, 5'd0,  32'h0,     32'h0,      1'b0, 8'h0, 32'h12345678, 4'd2}   // R2 pc write
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    mt_en = 1'b0; mt_num = '0; mt_data = '0; exc_req = 1'b0; exc_code = '0;
    exc_pc = '0; exc_addr = '0; rfe = 1'b0; irq_lines = '0;
  endtask

  task automatic rd(input logic [4:0] num, input logic [31:0] exp, input string tag);
    mf_num = num;
    tick();
    check(tag, mf_data, exp);
  endtask

  task automatic wr(input logic [4:0] num, input logic [31:0] dat);
    mt_en = 1'b1; mt_num = num; mt_data = dat;
    tick();
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    check("R10 irq_req after reset", {31'b0, irq_req}, 32'h0);
    check("R10 mf_data after reset", mf_data, 32'h0);

    for (int k = 0; k < 18; k++) begin
      mt_en = TBL[k].wr; mt_num = TBL[k].wnum; mt_data = TBL[k].wdat;
      mf_num = TBL[k].rnum; exc_req = TBL[k].exc; exc_code = TBL[k].code;
      exc_pc = TBL[k].pc; exc_addr = TBL[k].addr; rfe = TBL[k].ret;
      irq_lines = TBL[k].lines;
      tick();
      check($sformatf("R%0d vector %0d", TBL[k].req, k), mf_data, TBL[k].exp_rd);
    end
    idle();

    // Mask bit 2 only, IE-current on
    wr(5'd12, 32'h00000401);
    irq_lines = 8'h08; tick(); irq_lines = 8'h00;
    tick(); tick();
    check("R8 masked level gives no request", {31'b0, irq_req}, 32'h0);
    rd(5'd13, 32'h00000820, "R7 pending stays after line falls");

    irq_lines = 8'h04; tick(); irq_lines = 8'h00;
    check("R8 request lags pending by one edge", {31'b0, irq_req}, 32'h0);
    tick();
    check("R8 request raised", {31'b0, irq_req}, 32'h1);

    // Interrupt taken: code 0, IE-current drops
    exc_req = 1'b1; exc_code = 5'd0; exc_pc = 32'h600; tick(); idle();
    tick();
    check("R5 request drops after push disables", {31'b0, irq_req}, 32'h0);
    rd(5'd13, 32'h00000C00, "R3 interrupt code 0");

    // Exception and cause write collide
    mt_en = 1'b1; mt_num = 5'd13; mt_data = 32'h0;
    exc_req = 1'b1; exc_code = 5'd12; exc_pc = 32'h700;
    tick(); idle();
    rd(5'd13, 32'h00000C30, "R9 exception beats cause write");
    rd(5'd14, 32'h00000700, "R3 pc captured");

    // Cause write of zero while line 0 high
    mt_en = 1'b1; mt_num = 5'd13; mt_data = 32'h0; irq_lines = 8'h01;
    tick(); idle();
    rd(5'd13, 32'h00000130, "R7 line beats clearing write");
    wr(5'd13, 32'h0);
    rd(5'd13, 32'h00000030, "R2 cause write clears pending, code kept");

    // Return and status write collide
    rfe = 1'b1; mt_en = 1'b1; mt_num = 5'd12; mt_data = 32'h0000FFFF;
    tick(); idle();
    rd(5'd12, 32'h00000414, "R9 return beats status write");

    // Reset with activity present
    rst = 1'b1; mt_en = 1'b1; mt_num = 5'd12; mt_data = 32'h0000FF01; irq_lines = 8'hFF;
    tick();
    rst = 1'b0; idle();
    check("R10 mf_data cleared", mf_data, 32'h0);
    tick();
    check("R10 irq_req cleared", {31'b0, irq_req}, 32'h0);
    rd(5'd12, 32'h0, "R10 status cleared");
    rd(5'd13, 32'h0, "R10 cause cleared");
    rd(5'd14, 32'h0, "R10 return address cleared");
    rd(5'd8,  32'h0, "R10 fault address cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule